// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a simple on-chip request port and an external asynchronous static RAM holding 512K bytes. A client presents a read or a write with a 19-bit byte address (and 8-bit data for a write) under a valid/ready handshake. The controller then drives the memory's active-low select, output-enable and write-enable strobes, its address bus and a shared bidirectional data bus. It stretches each access over enough 10 ns clock cycles to cover the memory's minimum access, pulse, setup and hold times.

A read keeps select and output enable low for three cycles. The bus is sampled at the end of the third cycle, and the byte comes back with a one-cycle completion pulse. A write runs in three phases. First, a setup cycle presents the address and data while the write strobe is still high. Second, the write strobe is held low for two cycles. Third, a release cycle raises both strobes while the address is still held. The controller drives the data bus only during the write setup and pulse phases, so it never competes with the memory. At least one idle cycle with the memory deselected lies between any two accesses, and this gives the bus time to turn around.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and for the cycles it takes to release it, select, output enable and write enable are all high (1), `req_ready` is 1 and `rsp_valid` is 0.
- R2: In an idle cycle, select, output enable and write enable are high and `req_ready` is 1. In every cycle of an access `req_ready` is 0. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1.
- R3: A read (`req_write`=0) taken at edge k gives exactly three cycles with select low, output enable low, write enable high and the address bus equal to the request address. The controller returns to idle after that.
- R4: The data bus value at the end of the third read cycle appears on `rsp_rdata`, and `rsp_valid` is 1 for exactly that next cycle. `rsp_rdata` keeps its value until the next read completes, and writes never raise `rsp_valid`.
- R5: A write (`req_write`=1) first gives one setup cycle. In it, select is low, write enable and output enable are high, the address bus carries the request address and the controller drives the write byte onto the data bus.
- R6: Two write-pulse cycles follow the setup cycle. In them, select and write enable are low, output enable is high, and the address and driven data are unchanged.
- R7: One release cycle follows the pulse. In it, select and write enable are high again, the address is unchanged and the controller no longer drives the data bus. The controller is idle after that.
- R8: Address, data and direction are captured only at the accepting edge. Changes on the request inputs during an access have no effect on the memory pins, and the address is stable for the whole time select is low.
- R9: The controller drives the data bus only in the write setup and pulse cycles. Output enable is high in every write cycle, so it is never low together with write enable or while the controller drives.
- R10: A byte written to an address is returned by any later read of that address, including the lowest (0x00000) and highest (0x7FFFF) address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 8 | Read byte, held until the next read completes |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
The properties assume that the external memory drives the data bus only while select and output enable are low and write enable is high, so any drive seen at other times comes from the controller. They also assume that the request inputs are steady around the rising edge. The bench's memory model drives the bus only under those conditions and changes request signals only away from the rising edge. While an access is under way, the bench keeps `req_valid` high and changes the address, data and direction to junk values. This checks that these changes do not reach the pins, and the model leaves every request to be taken through the handshake alone.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_WSET  = 3'd2,
    PH_WLOW  = 3'd3,
    PH_WREL  = 3'd4
  } phase_e;

endpackage

// File: rtl/sram_async_rst_sync.sv
module sram_async_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sram_async_seq.sv
module sram_async_seq
  import sram_async_pkg::*;
#(
  parameter int RD_CYC     = 3,
  parameter int WR_LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_sample,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic wr_drive
);

  localparam int MAX_CYC = (RD_CYC > WR_LOW_CYC) ? RD_CYC : WR_LOW_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ce_n_d, oe_n_d, we_n_d, drive_d;

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    accept    = 1'b0;
    rd_sample = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          accept  = 1'b1;
          phase_d = req_write ? PH_WSET : PH_READ;
        end
      end
      PH_READ: begin
        if (cnt_q == RD_LAST) begin
          rd_sample = 1'b1;
          phase_d   = PH_IDLE;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WSET: begin
        phase_d = PH_WLOW;
        cnt_d   = '0;
      end
      PH_WLOW: begin
        if (cnt_q == WR_LAST) begin
          phase_d = PH_WREL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WREL: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // strobe decode of the coming phase, so the pins leave a flop
  always_comb begin
    ce_n_d  = (phase_d == PH_IDLE) || (phase_d == PH_WREL);
    oe_n_d  = (phase_d != PH_READ);
    we_n_d  = (phase_d != PH_WLOW);
    drive_d = (phase_d == PH_WSET) || (phase_d == PH_WLOW);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      wr_drive <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      ce_n     <= ce_n_d;
      oe_n     <= oe_n_d;
      we_n     <= we_n_d;
      wr_drive <= drive_d;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);

endmodule

// File: rtl/sram_async_dpath.sv
module sram_async_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_sample,
  input  logic              wr_drive,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  // request capture, enabled only at the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read capture at the end of the last read cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_sample) begin
      rdata_q <= mem_dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= rd_sample;
    end
  end

  assign mem_dq    = wr_drive ? wdata_q : {DATA_W{1'bz}};
  assign mem_addr  = addr_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int RD_CYC     = 3,
  parameter int WR_LOW_CYC = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  logic rst_sync_n;
  logic accept;
  logic rd_sample;
  logic wr_drive;

  sram_async_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_async_seq #(
    .RD_CYC     (RD_CYC),
    .WR_LOW_CYC (WR_LOW_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_sample (rd_sample),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .wr_drive  (wr_drive)
  );

  sram_async_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_sample),
    .wr_drive  (wr_drive),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_async_chk.sv
module sram_async_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              drive,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              rsp_valid
);

  // R9: controller drive and memory output enable never overlap
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> oe_n);

  // R9: output enable stays high whenever a write strobe is low
  a_r9_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  // R2: memory deselected whenever the controller is idle
  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && oe_n && we_n));

  // R8: address does not move while the memory stays selected
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  // R5: data is already driven in the cycle before the write strobe falls
  a_r5_data_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(drive));

  // R7: strobes rise together, address held, bus released
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (ce_n && !drive && $stable(addr)));

  // R4: a response only directly after a read strobe
  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!oe_n) && oe_n));

endmodule

bind sram_async_ctrl sram_async_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ce_n      (mem_ce_n),
  .oe_n      (mem_oe_n),
  .we_n      (mem_we_n),
  .drive     (wr_drive),
  .addr      (mem_addr),
  .ready     (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  logic [18:0] mem_addr;
  wire  [7:0]  mem_dq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit in_rst = 1;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] fill(input logic [18:0] a);
    return 8'(a * 7 + 19'(a >> 8) + 3);
  endfunction

  // ---------------- external memory model ----------------
  logic [7:0] sram [int];
  logic [7:0] sram_q;
  logic       sram_drv;
  assign sram_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq   = sram_drv ? sram_q : 8'bz;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) sram[int'(mem_addr)] = mem_dq;
    sram_q = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : fill(mem_addr);
  end

  // ---------------- reference model ----------------
  typedef struct {
    logic        ce, oe, we;
    logic [18:0] a;
    logic        chk_d;
    logic [7:0]  d;
    logic        rsp_next;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  exp_t       q[$];
  logic [7:0] shadow [int];
  bit         exp_rsp  = 0;
  bit         have_rd  = 0;
  bit         accepted = 0;
  logic [7:0] last_rd  = '0;

  function automatic exp_t mk(input logic ce, oe, we, input logic [18:0] a,
                              input logic chk_d, input logic [7:0] d,
                              input logic rsp_next, input logic [7:0] rd,
                              input string tag);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.a = a; e.chk_d = chk_d; e.d = d;
    e.rsp_next = rsp_next; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_rsp  = 0;
      accepted = 0;
    end else begin
      bit was_idle;
      was_idle = (q.size() == 0);
      accepted = 0;
      exp_rsp  = 0;
      if (!was_idle) begin
        exp_t e;
        e = q.pop_front();
        if (e.rsp_next) begin
          exp_rsp = 1; last_rd = e.rd; have_rd = 1;
        end
      end else if (req_valid) begin
        accepted = 1;
        if (req_write) begin
          shadow[int'(req_addr)] = req_wdata;
          q.push_back(mk(0, 1, 1, req_addr, 1, req_wdata, 0, 0, "R5"));
          q.push_back(mk(0, 1, 0, req_addr, 1, req_wdata, 0, 0, "R6"));
          q.push_back(mk(0, 1, 0, req_addr, 1, req_wdata, 0, 0, "R6"));
          q.push_back(mk(1, 1, 1, req_addr, 0, 0, 0, 0, "R7"));
        end else begin
          logic [7:0] v;
          v = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : fill(req_addr);
          q.push_back(mk(0, 0, 1, req_addr, 0, 0, 0, 0, "R3"));
          q.push_back(mk(0, 0, 1, req_addr, 0, 0, 0, 0, "R3"));
          q.push_back(mk(0, 0, 1, req_addr, 0, 0, 1, v, "R3"));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, mid-cycle
  always @(negedge clk) begin
    if ($time > 4) begin
      if (q.size() == 0) begin
        string t;
        t = in_rst ? "R1" : "R2";
        chk(mem_ce_n == 1'b1, t, "idle ce_n", 32'(mem_ce_n), 1);
        chk(mem_oe_n == 1'b1, t, "idle oe_n", 32'(mem_oe_n), 1);
        chk(mem_we_n == 1'b1, t, "idle we_n", 32'(mem_we_n), 1);
        chk(req_ready == 1'b1, t, "idle ready", 32'(req_ready), 1);
      end else begin
        exp_t e;
        string ot;
        e  = q[0];
        ot = (e.tag == "R3") ? "R3" : "R9";
        chk(mem_ce_n == e.ce, e.tag, "ce_n", 32'(mem_ce_n), 32'(e.ce));
        chk(mem_oe_n == e.oe, ot, "oe_n", 32'(mem_oe_n), 32'(e.oe));
        chk(mem_we_n == e.we, e.tag, "we_n", 32'(mem_we_n), 32'(e.we));
        chk(mem_addr == e.a, "R8", "address", 32'(mem_addr), 32'(e.a));
        chk(req_ready == 1'b0, "R2", "busy ready", 32'(req_ready), 0);
        if (e.chk_d) chk(mem_dq == e.d, e.tag, "write data", 32'(mem_dq), 32'(e.d));
      end
      chk(rsp_valid == exp_rsp, in_rst ? "R1" : "R4", "rsp_valid",
          32'(rsp_valid), 32'(exp_rsp));
      if (have_rd) chk(rsp_rdata == last_rd, "R10", "read data",
                       32'(rsp_rdata), 32'(last_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input logic w, input logic [18:0] a, input logic [7:0] d,
                        input bit junk);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do begin
      @(posedge clk); #1;
    end while (!accepted);
    req_valid = 0;
    if (junk) begin
      // R8: request inputs change while busy and must be ignored
      req_valid = 1; req_write = 1'($urandom); req_addr = 19'($urandom);
      req_wdata = 8'($urandom);
      @(negedge clk);
      req_write = 1'($urandom); req_addr = 19'($urandom); req_wdata = 8'($urandom);
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1;
    #2 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    in_rst = 0;
    idle(2);

    do_req(1, 19'h00000, 8'hA5, 0);     // R5 R6 R7 lowest address
    do_req(0, 19'h00000, 8'h00, 0);     // R3 R4 R10
    do_req(1, 19'h7FFFF, 8'hFF, 0);     // highest address
    do_req(1, 19'h00001, 8'h00, 0);
    do_req(0, 19'h7FFFF, 8'h00, 0);
    do_req(0, 19'h00001, 8'h00, 0);
    do_req(0, 19'h12345, 8'h00, 0);     // unwritten location
    idle(3);                            // R4 read data held
    do_req(1, 19'h2AAAA, 8'h3C, 1);     // R8 junk while busy
    do_req(0, 19'h2AAAA, 8'h00, 1);
    do_req(1, 19'h2AAAA, 8'hC3, 0);     // overwrite, read back
    do_req(0, 19'h2AAAA, 8'h00, 0);

    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      a = {1'($urandom), 14'b0, 4'($urandom)};
      if (($urandom % 5) == 0) a = 19'h7FFFF;
      do_req(1'($urandom), a, 8'($urandom), ($urandom % 4) == 0);
      if (($urandom % 3) == 0) idle(int'($urandom % 3));
    end
    idle(8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule